// File: doc/BRIEF.md
# Descriptor-Queued SPI Master with Chip-Select Hold

This block is an SPI master that executes transfers from a queue of command words. Each command word is a descriptor. It sets the transfer length from 1 to 32 bits, the SCLK rate, the clock polarity and phase, which of four chip-select lines to drive, and whether chip-select stays asserted when the transfer ends. Outgoing words wait in a transmit queue, and each descriptor consumes one of them. Every descriptor that runs leaves exactly one word in a receive queue.

A peripheral that needs a frame wider than 32 bits is served by chaining descriptors. Every descriptor in the chain except the last has its hold flag set. Chip-select then stays low from the first bit of the chain to the last. Each link still returns its own received word, and the host joins these words if it needs a wider value. A descriptor whose length field asks for more than 32 bits is rejected: it is removed from the queue, an error pulse is raised, and nothing is shifted.

Top module: `spi_desc_master`

## Requirements
- R1: A descriptor whose length field (bits [5:0], holding bits-minus-one) is 32 or more raises `len_err` for one cycle. It is dropped without SCLK activity, without a receive word and without consuming a transmit word.
- R2: When the hold flag (bit 30) is set, chip-select stays low after that descriptor's transfer ends.
- R3: When the hold flag is clear, chip-select returns high after that descriptor's last SCLK edge.
- R4: A 32-bit held descriptor followed by a 16-bit non-held descriptor gives one 48-bit frame with a single chip-select assertion, and returns two separate receive words.
- R5: A descriptor of n bits sends bits n-1 down to 0 of its transmit word on MOSI, most significant bit first, and produces exactly 2n SCLK edges.
- R6: The receive word holds the n sampled MISO bits right-justified, with zeros above them.
- R7: The divider field (bits [23:16]) value d makes every SCLK half period d+1 system clocks.
- R8: Bit 12 sets the SCLK idle level. Bit 13 picks the sampling edge: the leading edge when it is 0, the trailing edge when it is 1.
- R9: The chip-select field (bits [9:8]) selects which of the four active-low `cs_n` lines goes low. At most one line is ever low.
- R10: If the queue runs dry while a frame is held, chip-select stays low until a non-held descriptor completes.
- R11: `busy` is high while descriptors are queued, a transfer runs or chip-select is held, and low otherwise. When `busy` is low, every `cs_n` line is high.
- R12: Between the last edge of a held descriptor and the first edge of its continuation, there are at most 2(d+1)+2 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| desc_push | input | 1 | Write `desc_word` into the descriptor queue |
| desc_word | input | 32 | Descriptor word |
| desc_full | output | 1 | Descriptor queue full |
| tx_push | input | 1 | Write `tx_word` into the transmit queue |
| tx_word | input | 32 | Transmit data word |
| tx_full | output | 1 | Transmit queue full |
| rx_pop | input | 1 | Remove the head of the receive queue |
| rx_word | output | 32 | Head of the receive queue |
| rx_empty | output | 1 | Receive queue empty |
| len_err | output | 1 | One-cycle pulse for a rejected descriptor |
| busy | output | 1 | Transfer activity or held frame |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | SPI data out |
| miso | input | 1 | SPI data in |
| cs_n | output | 4 | Active-low chip-select lines |

## Verification
Two events can fall in the same cycle: the final half period of a held descriptor ends, and the next descriptor is accepted. When that happens, chip-select must not flicker and the receive word of the first link must not be lost. The bench provokes this by queueing a 32-bit held descriptor and a 16-bit closing descriptor back to back. It then judges at the pins: it counts chip-select releases, which must be exactly one, measures the longest gap between SCLK edges, and checks that the two receive words arrive separately, with the captured MOSI stream equal to the 48 queued bits. A second corner case is the queue emptying while a frame is held, followed later by the closing descriptor.

// File: rtl/spi_desc_pkg.sv
// Shared types and descriptor field decode for the descriptor-queued SPI master.
// Assumes a 32-bit descriptor word with the field positions listed in the brief.
package spi_desc_pkg;

    localparam int WORD_W  = 32;
    localparam int LEN_W   = 6;
    localparam int DIV_W   = 8;
    localparam int CSI_W   = 2;
    localparam int NCS     = 1 << CSI_W;
    localparam int MAX_LEN = WORD_W;

    typedef struct packed {
        logic             hold;
        logic             cpha;
        logic             cpol;
        logic [CSI_W-1:0] csi;
        logic [DIV_W-1:0] div;
        logic [LEN_W-1:0] len_m1;
    } desc_t;

    typedef enum logic {
        CTL_IDLE = 1'b0,
        CTL_RUN  = 1'b1
    } ctl_state_t;

    // Unpack a raw descriptor word into its fields.
    function automatic desc_t desc_decode(input logic [WORD_W-1:0] w);
        desc_t d;
        d.len_m1 = w[5:0];
        d.csi    = w[9:8];
        d.cpol   = w[12];
        d.cpha   = w[13];
        d.div    = w[23:16];
        d.hold   = w[30];
        return d;
    endfunction

endpackage

// File: rtl/spi_word_fifo.sv
// Show-ahead synchronous FIFO for word queues.
// A push into a full FIFO and a pop from an empty one are both ignored.
// DEPTH must be a power of two.
module spi_word_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    output logic         full,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [W-1:0]   mem [DEPTH];
    logic [PTR_W:0] wr_ptr, rd_ptr;
    logic           do_push, do_pop;

    assign empty   = (wr_ptr == rd_ptr);
    assign full    = (wr_ptr[PTR_W] != rd_ptr[PTR_W]) &&
                     (wr_ptr[PTR_W-1:0] == rd_ptr[PTR_W-1:0]);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr[PTR_W-1:0]];

    // Advance the pointers on accepted pushes and pops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // Store accepted data; the storage needs no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr[PTR_W-1:0]] <= wdata;
    end

endmodule

// File: rtl/spi_bit_engine.sv
// Shifts one descriptor's worth of bits on SCLK/MOSI/MISO.
// A start pulse loads the mode, the divider and the transmit word.
// The engine then runs one half period of setup, 2n clock edges and one half period of tail,
// and pulses done. The transmit word is sent MSB first from bit n-1.
// MOSI changes on trailing edges.
// MISO is sampled on the leading edge (phase 0) or on the trailing edge (phase 1).
// Assumes len_m1 < WORD_W at start.
module spi_bit_engine #(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 6,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic [DIV_W-1:0]  div,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              active,
    output logic              done,
    output logic [WORD_W-1:0] rx_word
);
    localparam int STEP_W = LEN_W + 2;

    logic              active_q, done_q, sclk_q, cpha_q;
    logic [DIV_W-1:0]  cnt, div_q;
    logic [STEP_W-1:0] step, last_step, step_nx;
    logic [WORD_W-1:0] tx_sh, rx_sh;
    logic [LEN_W-1:0]  sh_amt;
    logic              leading, sample_now;

    assign step_nx    = step + 1'b1;
    assign leading    = step_nx[0];
    assign sample_now = leading ^ cpha_q;
    assign sh_amt     = LEN_W'(WORD_W - 1) - len_m1;

    assign sclk    = sclk_q;
    assign mosi    = tx_sh[WORD_W-1];
    assign active  = active_q;
    assign done    = done_q;
    assign rx_word = rx_sh;

    // Half-period timer, edge sequencing and the two shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q  <= 1'b0;
            done_q    <= 1'b0;
            sclk_q    <= 1'b0;
            cpha_q    <= 1'b0;
            cnt       <= '0;
            div_q     <= '0;
            step      <= '0;
            last_step <= '0;
            tx_sh     <= '0;
            rx_sh     <= '0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                active_q  <= 1'b1;
                cnt       <= div;
                div_q     <= div;
                step      <= '0;
                last_step <= (STEP_W'(len_m1) << 1) + STEP_W'(3);
                tx_sh     <= tx_word << sh_amt;
                rx_sh     <= '0;
                sclk_q    <= cpol;
                cpha_q    <= cpha;
            end else if (active_q) begin
                if (cnt != '0) begin
                    cnt <= cnt - 1'b1;
                end else begin
                    cnt  <= div_q;
                    step <= step_nx;
                    if (step_nx == last_step) begin
                        active_q <= 1'b0;
                        done_q   <= 1'b1;
                    end else begin
                        sclk_q <= ~sclk_q;
                        if (sample_now) rx_sh <= {rx_sh[WORD_W-2:0], miso};
                        if (!leading)   tx_sh <= tx_sh << 1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/spi_desc_master.sv
// Descriptor-queued SPI master top.
// Three queues (descriptor, transmit, receive) feed a controller that rejects over-long
// descriptors and launches the bit engine. The controller also keeps chip-select asserted
// across descriptors whose hold flag is set.
// A descriptor starts only when a transmit word is queued and the receive queue has room,
// so no received word is ever dropped.
module spi_desc_master #(
    parameter int DESC_DEPTH = 4,
    parameter int TXQ_DEPTH  = 4,
    parameter int RXQ_DEPTH  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        desc_push,
    input  logic [31:0] desc_word,
    output logic        desc_full,
    input  logic        tx_push,
    input  logic [31:0] tx_word,
    output logic        tx_full,
    input  logic        rx_pop,
    output logic [31:0] rx_word,
    output logic        rx_empty,
    output logic        len_err,
    output logic        busy,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic [3:0]  cs_n
);
    import spi_desc_pkg::*;

    logic [WORD_W-1:0] dq_rdata, tq_rdata, eng_rx;
    logic              dq_empty, dq_pop, tq_empty, tq_pop, rq_full;
    logic              eng_active, eng_done, start;
    logic              bad_len, can_go, err_q, cs_on, hold_q;
    logic [CSI_W-1:0]  cs_sel;
    ctl_state_t        ctl_state;
    desc_t             cur;

    spi_word_fifo #(.W(WORD_W), .DEPTH(DESC_DEPTH)) u_desc_q (
        .clk(clk), .rst_n(rst_n), .push(desc_push), .wdata(desc_word), .full(desc_full),
        .pop(dq_pop), .rdata(dq_rdata), .empty(dq_empty)
    );

    spi_word_fifo #(.W(WORD_W), .DEPTH(TXQ_DEPTH)) u_tx_q (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_word), .full(tx_full),
        .pop(tq_pop), .rdata(tq_rdata), .empty(tq_empty)
    );

    spi_word_fifo #(.W(WORD_W), .DEPTH(RXQ_DEPTH)) u_rx_q (
        .clk(clk), .rst_n(rst_n), .push(eng_done), .wdata(eng_rx), .full(rq_full),
        .pop(rx_pop), .rdata(rx_word), .empty(rx_empty)
    );

    spi_bit_engine #(.WORD_W(WORD_W), .LEN_W(LEN_W), .DIV_W(DIV_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .len_m1(cur.len_m1), .div(cur.div),
        .cpol(cur.cpol), .cpha(cur.cpha), .tx_word(tq_rdata), .miso(miso),
        .sclk(sclk), .mosi(mosi), .active(eng_active), .done(eng_done), .rx_word(eng_rx)
    );

    // Decode the head descriptor and decide between reject, launch and wait.
    always_comb begin
        cur     = desc_decode(dq_rdata);
        bad_len = (ctl_state == CTL_IDLE) && !dq_empty && (int'(cur.len_m1) >= MAX_LEN);
        can_go  = (ctl_state == CTL_IDLE) && !dq_empty && !bad_len && !tq_empty && !rq_full;
        dq_pop  = bad_len || can_go;
        tq_pop  = can_go;
        start   = can_go;
    end

    // Controller state, chip-select ownership and the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_state <= CTL_IDLE;
            err_q     <= 1'b0;
            cs_on     <= 1'b0;
            cs_sel    <= '0;
            hold_q    <= 1'b0;
        end else begin
            err_q <= bad_len;
            if (can_go) begin
                ctl_state <= CTL_RUN;
                cs_on     <= 1'b1;
                cs_sel    <= cur.csi;
                hold_q    <= cur.hold;
            end else if (ctl_state == CTL_RUN && eng_done) begin
                ctl_state <= CTL_IDLE;
                if (!hold_q) cs_on <= 1'b0;
            end
        end
    end

    // One active-low select line per chip-select index.
    for (genvar i = 0; i < NCS; i++) begin : g_cs
        assign cs_n[i] = !(cs_on && (cs_sel == CSI_W'(i)));
    end

    assign len_err = err_q;
    assign busy    = !dq_empty || (ctl_state == CTL_RUN) || cs_on;

endmodule

// File: rtl/spi_desc_master_chk.sv
// Protocol checker for spi_desc_master. It is bound into every instance of the top.
// It reads the pins plus the engine activity, done and hold state.
module spi_desc_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] cs_n,
    input logic       sclk,
    input logic       busy,
    input logic       len_err,
    input logic       eng_active,
    input logic       eng_done,
    input logic       hold_q
);
    // R9: never more than one chip-select low.
    assert_cs_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R1: a rejected descriptor never coincides with a running transfer.
    assert_err_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> !eng_active);

    // R11: idle means every select line is released.
    assert_idle_cs_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (&cs_n));

    // R8: SCLK moves only while some chip-select is asserted.
    assert_sclk_framed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk != $past(sclk)) |-> !(&cs_n));

    // R2: a held descriptor leaves chip-select low after it completes.
    assert_hold_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && hold_q) |=> !(&cs_n));

    // R3: a non-held descriptor releases chip-select after it completes.
    assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && !hold_q) |=> (&cs_n));
endmodule

bind spi_desc_master spi_desc_master_chk chk_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .busy(busy), .len_err(len_err),
    .eng_active(eng_active), .eng_done(eng_done), .hold_q(hold_q)
);

// File: tb/spi_desc_master_tb_top.sv
// Self-checking bench: MOSI is looped back to MISO, and a pin monitor records edges,
// half periods, chip-select activity and the MOSI bits seen on the sampling edges.
module spi_desc_master_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        desc_push = 1'b0, tx_push = 1'b0, rx_pop = 1'b0;
    logic [31:0] desc_word = '0, tx_word = '0;
    logic        desc_full, tx_full, rx_empty, len_err, busy, sclk, mosi;
    logic [31:0] rx_word;
    logic [3:0]  cs_n;

    int n_checks = 0, n_errs = 0;
    bit finished = 0;

    spi_desc_master dut_i (
        .clk(clk), .rst_n(rst_n), .desc_push(desc_push), .desc_word(desc_word),
        .desc_full(desc_full), .tx_push(tx_push), .tx_word(tx_word), .tx_full(tx_full),
        .rx_pop(rx_pop), .rx_word(rx_word), .rx_empty(rx_empty), .len_err(len_err),
        .busy(busy), .sclk(sclk), .mosi(mosi), .miso(mosi), .cs_n(cs_n)
    );

    always #10 clk = ~clk;

    // Monitor state
    bit          mon_cpol, mon_cpha, clr_req, have_last;
    int          cyc, last_t, edges, ncap, min_half, max_half, cs_rise, err_cnt;
    logic [63:0] cap;
    logic [3:0]  cs_seen, prev_cs = 4'hF;
    logic        prev_sclk = 1'b0, prev_mosi = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (clr_req) begin
            edges = 0; ncap = 0; cap = '0; min_half = 1 << 30; max_half = 0;
            cs_rise = 0; err_cnt = 0; cs_seen = '0; have_last = 0; clr_req = 0;
        end
        if (!(&cs_n)) cs_seen |= ~cs_n;
        if ((&cs_n) && !(&prev_cs)) cs_rise++;
        if (len_err) err_cnt++;
        if (sclk != prev_sclk && !(&prev_cs) && !(&cs_n)) begin
            edges++;
            if (have_last) begin
                if (cyc - last_t < min_half) min_half = cyc - last_t;
                if (cyc - last_t > max_half) max_half = cyc - last_t;
            end
            last_t = cyc; have_last = 1;
            if ((prev_sclk == mon_cpol) != mon_cpha) begin
                cap = {cap[62:0], prev_mosi};
                ncap++;
            end
        end
        prev_sclk = sclk; prev_mosi = mosi; prev_cs = cs_n;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] make_desc(int len, int div, bit cpol, bit cpha,
                                              int csi, bit hold);
        logic [31:0] w = '0;
        w[5:0]   = 6'(len - 1);
        w[9:8]   = 2'(csi);
        w[12]    = cpol;
        w[13]    = cpha;
        w[23:16] = 8'(div);
        w[30]    = hold;
        return w;
    endfunction

    function automatic logic [31:0] lowbits(logic [31:0] v, int n);
        return (n >= 32) ? v : (v & ((32'h1 << n) - 1));
    endfunction

    task automatic clear_mon(input bit cpol, input bit cpha);
        mon_cpol = cpol; mon_cpha = cpha; clr_req = 1;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic push_desc(input logic [31:0] w);
        @(negedge clk); desc_word = w; desc_push = 1;
        @(negedge clk); desc_push = 0;
    endtask

    task automatic push_tx(input logic [31:0] w);
        @(negedge clk); tx_word = w; tx_push = 1;
        @(negedge clk); tx_push = 0;
    endtask

    task automatic pop_rx(output logic [31:0] w);
        int t = 0;
        @(negedge clk);
        while (rx_empty && t < 20000) begin @(negedge clk); t++; end
        w = rx_word; rx_pop = 1;
        @(negedge clk); rx_pop = 0;
    endtask

    // One non-held transfer, judged at the pins.
    task automatic single(input int len, input int div, input bit cpol, input bit cpha,
                          input int csi, input logic [31:0] tx);
        logic [31:0] got, exp;
        exp = lowbits(tx, len);
        clear_mon(cpol, cpha);
        push_tx(tx);
        push_desc(make_desc(len, div, cpol, cpha, csi, 0));
        check(busy == 1'b1, "R11 busy during transfer", 64'(busy), 64'd1);
        pop_rx(got);
        repeat (3) @(negedge clk);
        check(got == exp, "R6 rx right-justified", 64'(got), 64'(exp));
        check(ncap == len && cap[31:0] == exp, "R5 mosi msb first", cap, 64'(exp));
        check(edges == 2 * len, "R5 edge count", 64'(edges), 64'(2 * len));
        if (len > 1)
            check(min_half == div + 1 && max_half == div + 1, "R7 half period",
                  64'(max_half), 64'(div + 1));
        check(cs_seen == 4'(1 << csi), "R9 cs line select", 64'(cs_seen), 64'(1 << csi));
        check(cs_rise == 1 && (&cs_n), "R3 cs released", 64'(cs_rise), 64'd1);
        check(sclk == cpol, "R8 idle level", 64'(sclk), 64'(cpol));
        check(busy == 1'b0, "R11 idle after", 64'(busy), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_errs++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

    initial begin
        logic [31:0] w1, w2, r;
        void'($urandom(32'h1357));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // Reset state (R11, R3)
        check(&cs_n, "R3 reset cs high", 64'(cs_n), 64'hF);
        check(!busy && rx_empty && !desc_full, "R11 reset idle", 64'(busy), 64'd0);

        // Directed: all four modes (R8)
        for (int m = 0; m < 4; m++) single(8, 1, m[1], m[0], 2, 32'h0000_00A7);
        single(32, 0, 0, 0, 0, 32'hDEAD_BEEF);
        single(1, 2, 1, 1, 3, 32'h0000_0001);

        // R1: over-long descriptors are dropped; the queued tx word survives
        clear_mon(0, 0);
        push_tx(32'hA5A5_1234);
        push_desc(make_desc(33, 0, 0, 0, 1, 0));
        push_desc(make_desc(64, 0, 0, 0, 1, 1));
        repeat (20) @(negedge clk);
        check(err_cnt == 2, "R1 error pulses", 64'(err_cnt), 64'd2);
        check(edges == 0 && cs_seen == 0, "R1 no activity", 64'(edges), 64'd0);
        check(rx_empty && !busy, "R1 no rx word", 64'(rx_empty), 64'd1);
        push_desc(make_desc(16, 0, 0, 0, 1, 0));
        pop_rx(r);
        check(r == 32'h0000_1234, "R1 tx word kept", 64'(r), 64'h1234);

        // R4 / R12: 32 held + 16 closing gives one 48-bit frame
        w1 = $urandom; w2 = $urandom;
        clear_mon(1, 0);
        push_tx(w1); push_tx(w2);
        push_desc(make_desc(32, 1, 1, 0, 2, 1));
        push_desc(make_desc(16, 1, 1, 0, 2, 0));
        pop_rx(r);
        check(r == w1, "R4 first word", 64'(r), 64'(w1));
        pop_rx(r);
        repeat (3) @(negedge clk);
        check(r == lowbits(w2, 16), "R4 second word separate", 64'(r), 64'(lowbits(w2, 16)));
        check(cs_rise == 1, "R4 single cs assertion", 64'(cs_rise), 64'd1);
        check(ncap == 48 && cap[47:0] == {w1, w2[15:0]}, "R4 48-bit stream", cap,
              {16'h0, w1, w2[15:0]});
        check(max_half <= 2 * 2 + 2 && min_half == 2, "R12 continuation gap",
              64'(max_half), 64'd6);

        // R2 / R10: the queue runs dry while the frame is held
        clear_mon(0, 1);
        push_tx(32'h0000_003C);
        push_desc(make_desc(8, 0, 0, 1, 3, 1));
        pop_rx(r);
        repeat (50) @(negedge clk);
        check(cs_n == 4'b0111, "R2 cs held after", 64'(cs_n), 64'h7);
        check(busy == 1'b1, "R10 busy while held", 64'(busy), 64'd1);
        check(cs_rise == 0, "R10 no release", 64'(cs_rise), 64'd0);
        push_tx(32'h0000_00C3);
        push_desc(make_desc(8, 0, 0, 1, 3, 0));
        pop_rx(r);
        repeat (3) @(negedge clk);
        check(r == 32'hC3, "R6 closing word", 64'(r), 64'hC3);
        check(cs_rise == 1 && !busy, "R10 released at close", 64'(cs_rise), 64'd1);
        check(ncap == 16 && cap[15:0] == 16'h3CC3, "R5 held stream", cap, 64'h3CC3);

        // Random single transfers
        for (int i = 0; i < 24; i++) begin
            single(int'($urandom_range(32, 1)), int'($urandom_range(3, 0)),
                   1'($urandom), 1'($urandom), int'($urandom_range(3, 0)), $urandom);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end
endmodule